// File: doc/BRIEF.md
# Per-Processor Interrupt Pending Register Bank

This block keeps one 32-bit interrupt pending word for each of up to sixteen processors. It turns each word into sixteen processor-interrupt-level (PIL) lines for that processor. Each processor reaches its own word over a simple register bus. The processor index comes from address bits [15:12], so every processor's window sits on its own 4 KB page. The word index comes from address bits [3:2].

Through this bus a processor can read its pending word, set software interrupt bits and clear software interrupt bits. The software bits live in the upper half of the word and are shifted down onto the PIL lines.

The lower half of each word mirrors a hardware-interrupt vector supplied per processor by a companion routing block. That half reaches the PIL lines only for the processor that is currently the routing target, and only while routing is enabled and some enabled system interrupt is pending. Each processor also has a local timer line. Edges on that line set or clear one software bit, chosen at build time by `TIMER_BIT`, which must lie in [31:17].

Top module: `cpu_pend_intc`

## Requirements
- R1: The processor index is `bus_addr[15:12]` and the word index is `bus_addr[3:2]`. All other address bits are ignored, and an access touches only the addressed processor's word.
- R2: A read strobe loads `bus_rdata` at the clock edge where `bus_rd` is sampled high, and the value is held until the next read. Word 0 returns the addressed pending word as it was before that edge. Words 1, 2 and 3 return zero.
- R3: A write to word 1 clears pending bits. The write data is masked to bits [31:17], so lower bits clear nothing. If data bit 14 is 1, pending bit 31 is cleared as well.
- R4: A write to word 2 sets pending bits, with the data masked to bits [31:17].
- R5: Writes to word 0 and word 3 change no state.
- R6: PIL line j of a processor always carries pending bit 16+j, for j = 0 to 15.
- R7: Pending bits [15:1] are ORed onto PIL lines [15:1] only when three conditions hold together: `tgt_cpu` equals the processor's index, `route_en` is 1 and `sys_pend_any` is 1.
- R8: Pending bits [15:1] take the value of the processor's `hw_lvl` slice [15:1] at every clock edge. Pending bits 0 and 16 are always 0.
- R9: A rising edge of `tmr_lvl[c]` sets pending bit `TIMER_BIT` (default 30), and a falling edge clears it. A steady level has no effect, so a software clear sticks while the line stays high. A timer edge wins over a software set or clear of the same bit in the same cycle.
- R10: While reset is asserted, all pending words, all PIL lines and `bus_rdata` are zero.
- R11: The PIL lines are registered. They reflect the pending word and the routing inputs as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tgt_cpu | input | 4 | Processor currently targeted by the routing block |
| route_en | input | 1 | Routing enabled qualifier |
| sys_pend_any | input | 1 | At least one enabled system interrupt is pending |
| hw_lvl | input | 256 | Hardware vector, 16 bits per processor (processor c at [16c+15:16c]) |
| tmr_lvl | input | 16 | Local timer level, one per processor |
| pil | output | 256 | PIL lines, 16 per processor (processor c at [16c+15:16c]) |

## Verification
The timing of each result differs, and the bench samples each one on the negedge where it first becomes due.

- A bus write or a timer edge driven before clock edge k updates the pending word at edge k. The PIL lines follow at edge k+1. The bench therefore checks that PIL is still unchanged at the negedge after edge k, then checks the new value one negedge later.
- A change on `tgt_cpu`, `route_en` or `sys_pend_any` shows up on PIL at the first edge, and is checked at the very next negedge.
- A change on the hardware vector needs two edges to reach PIL, so the bench waits two edges before checking it.
- Read data is sampled at the negedge that follows the edge which captured the read strobe.

// File: rtl/cpi_pkg.sv
`timescale 1ns/1ps
package cpi_pkg;
  localparam int REG_W     = 32;
  localparam int PIL_N     = 16;
  localparam int WORD_LSB  = 2;
  localparam int QUIRK_SRC = 14;
  localparam int QUIRK_DST = REG_W - 1;
  localparam logic [REG_W-1:0] SOFT_WR_MASK = 32'hFFFE_0000;
  localparam logic [PIL_N-1:0] HARD_MASK    = 16'hFFFE;

  typedef enum logic [1:0] {
    W_PEND = 2'd0,
    W_CLR  = 2'd1,
    W_SET  = 2'd2,
    W_NONE = 2'd3
  } word_e;

  // Bits a set command may raise.
  function automatic logic [REG_W-1:0] set_bits(input logic [REG_W-1:0] wd);
    return wd & SOFT_WR_MASK;
  endfunction

  // Bits a clear command drops: bit 14 of the data also hits the top bit.
  function automatic logic [REG_W-1:0] clr_bits(input logic [REG_W-1:0] wd);
    logic [REG_W-1:0] t;
    t = wd;
    if (wd[QUIRK_SRC]) t[QUIRK_DST] = 1'b1;
    return t & SOFT_WR_MASK;
  endfunction

  // Level lines: soft half shifted down, hard half only when routed.
  function automatic logic [PIL_N-1:0] pil_of(input logic [REG_W-1:0] p,
                                               input logic route);
    logic [PIL_N-1:0] r;
    r = p[REG_W-1:PIL_N];
    if (route) r = r | (p[PIL_N-1:0] & HARD_MASK);
    return r;
  endfunction

  // Next pending word; timer edges are applied last and therefore win.
  function automatic logic [REG_W-1:0] next_pend(input logic [REG_W-1:0] cur,
                                                 input logic do_set,
                                                 input logic do_clr,
                                                 input logic [REG_W-1:0] wd,
                                                 input logic [PIL_N-1:0] hw,
                                                 input logic rise,
                                                 input logic fall,
                                                 input int tbit);
    logic [REG_W-1:0] n;
    n = {cur[REG_W-1:PIL_N], hw & HARD_MASK};
    if (do_clr) n = n & ~clr_bits(wd);
    if (do_set) n = n | set_bits(wd);
    if (rise)   n[tbit] = 1'b1;
    if (fall)   n[tbit] = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/cpi_bus_decode.sv
`timescale 1ns/1ps
module cpi_bus_decode import cpi_pkg::*; #(
  parameter int NUM_CPU = 16,
  parameter int ADDR_W  = 16,
  parameter int CPU_LSB = 12,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [CPU_W-1:0]   cpu_idx,
  output logic [NUM_CPU-1:0] set_hit,
  output logic [NUM_CPU-1:0] clr_hit,
  output logic               rd_any,
  output logic               rd_pend
);
  word_e word;
  logic  unused_addr;

  assign cpu_idx     = bus_addr[CPU_LSB +: CPU_W];
  assign word        = word_e'(bus_addr[WORD_LSB +: 2]);
  assign rd_any      = bus_rd;
  assign rd_pend     = bus_rd && (word == W_PEND);
  assign unused_addr = ^bus_addr;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_hit
    assign set_hit[c] = bus_wr && (word == W_SET) && (cpu_idx == CPU_W'(c));
    assign clr_hit[c] = bus_wr && (word == W_CLR) && (cpu_idx == CPU_W'(c));
  end
endmodule

// File: rtl/cpi_route.sv
`timescale 1ns/1ps
module cpi_route #(
  parameter int NUM_CPU = 16,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [CPU_W-1:0]   tgt_cpu,
  input  logic               route_en,
  input  logic               sys_pend_any,
  output logic [NUM_CPU-1:0] route_ok
);
  logic gate;
  assign gate = route_en && sys_pend_any;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_rt
    assign route_ok[c] = gate && (tgt_cpu == CPU_W'(c));
  end
endmodule

// File: rtl/cpi_pend_slice.sv
`timescale 1ns/1ps
module cpi_pend_slice import cpi_pkg::*; #(
  parameter int TIMER_BIT = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_hit,
  input  logic             clr_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             tmr_lvl,
  input  logic [PIL_N-1:0] hw_bits,
  input  logic             route_ok,
  output logic [REG_W-1:0] pend,
  output logic [PIL_N-1:0] pil,
  output logic             tmr_rise,
  output logic             tmr_fall
);
  logic             tmr_q;
  logic [REG_W-1:0] pend_d;

  assign tmr_rise = tmr_lvl & ~tmr_q;
  assign tmr_fall = ~tmr_lvl & tmr_q;

  always_comb begin
    pend_d = next_pend(pend, set_hit, clr_hit, wdata, hw_bits,
                       tmr_rise, tmr_fall, TIMER_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      tmr_q <= 1'b0;
      pil   <= '0;
    end else begin
      pend  <= pend_d;
      tmr_q <= tmr_lvl;
      pil   <= pil_of(pend, route_ok);
    end
  end
endmodule

// File: rtl/cpi_rd_port.sv
`timescale 1ns/1ps
module cpi_rd_port import cpi_pkg::*; #(
  parameter int NUM_CPU = 16,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_any,
  input  logic                     rd_pend,
  input  logic [CPU_W-1:0]         cpu_idx,
  input  logic [NUM_CPU*REG_W-1:0] pend_flat,
  output logic [REG_W-1:0]         rdata
);
  logic [REG_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_idx == CPU_W'(c)) sel = pend_flat[c*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_any) rdata <= rd_pend ? sel : '0;
  end
endmodule

// File: rtl/cpu_pend_intc.sv
`timescale 1ns/1ps
module cpu_pend_intc import cpi_pkg::*; #(
  parameter int NUM_CPU   = 16,
  parameter int ADDR_W    = 16,
  parameter int CPU_LSB   = 12,
  parameter int TIMER_BIT = 30,
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [REG_W-1:0]         bus_wdata,
  output logic [REG_W-1:0]         bus_rdata,
  input  logic [CPU_W-1:0]         tgt_cpu,
  input  logic                     route_en,
  input  logic                     sys_pend_any,
  input  logic [NUM_CPU*PIL_N-1:0] hw_lvl,
  input  logic [NUM_CPU-1:0]       tmr_lvl,
  output logic [NUM_CPU*PIL_N-1:0] pil
);
  // Named internal events, visible to the bound checker.
  logic [CPU_W-1:0]         cpu_idx;
  logic [NUM_CPU-1:0]       set_hit;
  logic [NUM_CPU-1:0]       clr_hit;
  logic [NUM_CPU-1:0]       route_ok;
  logic [NUM_CPU-1:0]       tmr_rise;
  logic [NUM_CPU-1:0]       tmr_fall;
  logic [NUM_CPU*REG_W-1:0] pend_flat;
  logic                     rd_any;
  logic                     rd_pend;

  cpi_bus_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_LSB(CPU_LSB)) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .cpu_idx  (cpu_idx),
    .set_hit  (set_hit),
    .clr_hit  (clr_hit),
    .rd_any   (rd_any),
    .rd_pend  (rd_pend)
  );

  cpi_route #(.NUM_CPU(NUM_CPU)) u_route (
    .tgt_cpu      (tgt_cpu),
    .route_en     (route_en),
    .sys_pend_any (sys_pend_any),
    .route_ok     (route_ok)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    cpi_pend_slice #(.TIMER_BIT(TIMER_BIT)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_hit  (set_hit[c]),
      .clr_hit  (clr_hit[c]),
      .wdata    (bus_wdata),
      .tmr_lvl  (tmr_lvl[c]),
      .hw_bits  (hw_lvl[c*PIL_N +: PIL_N]),
      .route_ok (route_ok[c]),
      .pend     (pend_flat[c*REG_W +: REG_W]),
      .pil      (pil[c*PIL_N +: PIL_N]),
      .tmr_rise (tmr_rise[c]),
      .tmr_fall (tmr_fall[c])
    );
  end

  cpi_rd_port #(.NUM_CPU(NUM_CPU)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_any    (rd_any),
    .rd_pend   (rd_pend),
    .cpu_idx   (cpu_idx),
    .pend_flat (pend_flat),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/cpi_chk.sv
`timescale 1ns/1ps
module cpi_chk #(
  parameter int NUM_CPU   = 16,
  parameter int ADDR_W    = 16,
  parameter int CPU_LSB   = 12,
  parameter int TIMER_BIT = 30,
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [NUM_CPU*32-1:0] pend_flat,
  input logic [NUM_CPU*16-1:0] pil,
  input logic [NUM_CPU-1:0]    route_ok,
  input logic [NUM_CPU-1:0]    set_hit,
  input logic [NUM_CPU-1:0]    clr_hit,
  input logic [NUM_CPU-1:0]    tmr_rise,
  input logic [NUM_CPU-1:0]    tmr_fall
);
  logic [1:0]  wsel;
  logic [31:0] rd_view;
  logic [31:0] set_view;
  logic [31:0] clr_view;
  logic [31:0] tmask;
  logic        unused_chk;

  assign wsel       = bus_addr[3:2];
  assign rd_view    = pend_flat[int'(bus_addr[CPU_LSB +: CPU_W])*32 +: 32];
  assign tmask      = ~(32'h1 << TIMER_BIT);
  assign set_view   = {bus_wdata[31:17], 17'b0} & tmask;
  assign clr_view   = {bus_wdata[31] | bus_wdata[14], bus_wdata[30:17], 17'b0} & tmask;
  assign unused_chk = ^{bus_addr, bus_wdata};

  a_r2_rd_word0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && wsel == 2'd0) |=> bus_rdata == $past(rd_view));
  a_r2_rd_other: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && wsel != 2'd0) |=> bus_rdata == 32'h0);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[c] |=> (pend_flat[c*32 +: 32] & $past(clr_view)) == 32'h0);
    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[c] |=> (pend_flat[c*32 +: 32] & $past(set_view)) == $past(set_view));
    a_r6_unrouted: assert property (@(posedge clk) disable iff (!rst_n)
      !route_ok[c] |=> pil[c*16 +: 16] == $past(pend_flat[c*32+16 +: 16]));
    a_r7_routed: assert property (@(posedge clk) disable iff (!rst_n)
      route_ok[c] |=> pil[c*16 +: 16] ==
        ($past(pend_flat[c*32+16 +: 16]) | ($past(pend_flat[c*32 +: 16]) & 16'hFFFE)));
    a_r8_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_flat[c*32] == 1'b0) && (pend_flat[c*32+16] == 1'b0));
    a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_rise[c] |=> pend_flat[c*32+TIMER_BIT]);
    a_r9_fall: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_fall[c] |=> !pend_flat[c*32+TIMER_BIT]);
  end
endmodule

bind cpu_pend_intc cpi_chk #(
  .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_LSB(CPU_LSB), .TIMER_BIT(TIMER_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pend_flat (pend_flat),
  .pil       (pil),
  .route_ok  (route_ok),
  .set_hit   (set_hit),
  .clr_hit   (clr_hit),
  .tmr_rise  (tmr_rise),
  .tmr_fall  (tmr_fall)
);

// File: tb/cpu_pend_intc_tb.sv
`timescale 1ns/1ps
module cpu_pend_intc_tb;
  localparam int NC = 16;
  localparam int TB = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   bus_addr;
  logic          bus_wr, bus_rd;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [3:0]    tgt_cpu;
  logic          route_en, sys_pend_any;
  logic [NC*16-1:0] hw_lvl;
  logic [NC-1:0] tmr_lvl;
  logic [NC*16-1:0] pil;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [31:0] m [NC];

  always #2.5 clk = ~clk;

  cpu_pend_intc #(.TIMER_BIT(TB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_cpu(tgt_cpu), .route_en(route_en),
    .sys_pend_any(sys_pend_any), .hw_lvl(hw_lvl), .tmr_lvl(tmr_lvl), .pil(pil)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Expected level lines, worked out bit by bit from R6 and R7.
  function automatic logic [15:0] e_pil(int c);
    logic [15:0] r;
    bit rt;
    rt = (int'(tgt_cpu) == c) && route_en && sys_pend_any;
    for (int j = 0; j < 16; j++)
      r[j] = m[c][16+j] | (rt && (j != 0) && m[c][j]);
    return r;
  endfunction

  task automatic chk_pils(string tag);
    for (int c = 0; c < NC; c++)
      chk(tag, {16'h0, pil[c*16 +: 16]}, {16'h0, e_pil(c)}, $sformatf("pil cpu%0d", c));
  endtask

  function automatic logic [15:0] mk_addr(int cpu, int word, logic [15:0] junk);
    return 16'((cpu << 12) | (word << 2)) | (junk & 16'h0FF3);
  endfunction

  task automatic bus_write(int cpu, int word, logic [31:0] d, logic [15:0] junk = 16'h0);
    bus_addr = mk_addr(cpu, word, junk); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic bus_read(int cpu, int word, output logic [31:0] d, input logic [15:0] junk = 16'h0);
    bus_addr = mk_addr(cpu, word, junk); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R10", bus_rdata, 32'h0, "rdata after reset");
    chk_pils("R10");
    bus_read(0, 0, d);  chk("R10", d, 32'h0, "cpu0 pending after reset");
    bus_read(15, 0, d); chk("R10", d, 32'h0, "cpu15 pending after reset");
  endtask

  task automatic t_soft;
    logic [31:0] d;
    bus_write(3, 2, 32'hFFFF_FFFF);
    chk("R11", {16'h0, pil[3*16 +: 16]}, 32'h0, "pil cpu3 one edge after write");
    m[3] = m[3] | 32'hFFFE_0000;
    wait_n(1); chk_pils("R6");
    bus_read(3, 0, d); chk("R4", d, 32'hFFFE_0000, "set masked to 31:17");
    bus_write(3, 1, 32'h0000_4000); m[3][31] = 1'b0;
    wait_n(1); chk_pils("R3");
    bus_read(3, 0, d); chk("R3", d, 32'h7FFE_0000, "bit14 clears bit31");
    bus_write(3, 1, 32'h0001_BFFF);
    bus_read(3, 0, d); chk("R3", d, 32'h7FFE_0000, "low bits clear nothing");
    bus_write(3, 1, 32'h0006_0000); m[3] = m[3] & ~32'h0006_0000;
    wait_n(1); chk_pils("R6");
    bus_read(3, 0, d); chk("R3", d, 32'h7FF8_0000, "bits 17,18 cleared");
  endtask

  task automatic t_read_words;
    logic [31:0] d;
    for (int w = 1; w < 4; w++) begin
      bus_read(3, w, d); chk("R2", d, 32'h0, $sformatf("read word %0d", w));
    end
    bus_read(3, 0, d); chk("R2", d, m[3], "read word 0");
  endtask

  task automatic t_undef;
    logic [31:0] d;
    bus_write(5, 3, 32'hFFFF_FFFF);
    bus_write(5, 0, 32'hFFFF_FFFF);
    wait_n(1); chk_pils("R5");
    bus_read(5, 0, d); chk("R5", d, 32'h0, "word0/word3 writes ignored");
  endtask

  task automatic t_decode;
    logic [31:0] d;
    bus_write(5, 2, 32'h0010_0000, 16'hFFFF); m[5] = m[5] | 32'h0010_0000;
    wait_n(1); chk_pils("R1");
    bus_read(5, 0, d, 16'hFFFF); chk("R1", d, 32'h0010_0000, "junk address bits ignored");
    bus_read(4, 0, d); chk("R1", d, 32'h0, "neighbour cpu untouched");
  endtask

  task automatic t_hw;
    logic [31:0] d;
    tgt_cpu = 4'd2; route_en = 1'b1; sys_pend_any = 1'b1;
    hw_lvl[2*16 +: 16] = 16'h00A7; m[2][15:0] = 16'h00A6;
    hw_lvl[4*16 +: 16] = 16'h0F00; m[4][15:0] = 16'h0F00;
    wait_n(2); chk_pils("R7");
    bus_read(2, 0, d); chk("R8", d, 32'h0000_00A6, "hard half mirrors vector, bit0 zero");
    tgt_cpu = 4'd3; wait_n(1); chk_pils("R11");
    tgt_cpu = 4'd4; wait_n(1); chk_pils("R7");
    route_en = 1'b0; wait_n(1); chk_pils("R7");
    route_en = 1'b1; sys_pend_any = 1'b0; wait_n(1); chk_pils("R7");
    sys_pend_any = 1'b1; wait_n(1); chk_pils("R7");
    hw_lvl = '0; m[2][15:0] = 16'h0; m[4][15:0] = 16'h0;
    wait_n(2); chk_pils("R8");
    route_en = 1'b0; wait_n(1);
  endtask

  task automatic t_timer;
    logic [31:0] d;
    tmr_lvl[7] = 1'b1; m[7][TB] = 1'b1;
    wait_n(2); chk_pils("R9");
    bus_read(7, 0, d); chk("R9", d, 32'h4000_0000, "timer rise sets bit");
    bus_write(7, 1, 32'h4000_0000); m[7][TB] = 1'b0;
    wait_n(3);
    bus_read(7, 0, d); chk("R9", d, 32'h0, "clear sticks while level high");
    tmr_lvl[7] = 1'b0; wait_n(2);
    tmr_lvl[7] = 1'b1; m[7][TB] = 1'b1; wait_n(2); chk_pils("R9");
    tmr_lvl[7] = 1'b0; m[7][TB] = 1'b0; wait_n(2); chk_pils("R9");
    bus_read(7, 0, d); chk("R9", d, 32'h0, "timer fall clears bit");
  endtask

  task automatic t_collision;
    logic [31:0] d;
    tmr_lvl[9] = 1'b1;
    bus_write(9, 1, 32'h4000_0000); m[9][TB] = 1'b1;
    bus_read(9, 0, d); chk("R9", d, 32'h4000_0000, "rise beats same-cycle clear");
    tmr_lvl[9] = 1'b0;
    bus_write(9, 2, 32'h4000_0000); m[9][TB] = 1'b0;
    bus_read(9, 0, d); chk("R9", d, 32'h0, "fall beats same-cycle set");
    wait_n(1); chk_pils("R9");
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    tgt_cpu = '0; route_en = 1'b0; sys_pend_any = 1'b0; hw_lvl = '0; tmr_lvl = '0;
    for (int c = 0; c < NC; c++) m[c] = 32'h0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_soft();
    t_read_words();
    t_undef();
    t_decode();
    t_hw();
    t_timer();
    t_collision();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule